// File: doc/BRIEF.md
# FIFO Window Length Gate

This block sits between the byte-stream data path of a card-side bus function and a DMA-style stream port with valid/ready handshakes. It watches commands aimed at a reserved address window of one function. The start address of such a command fixes how many bytes are real: the requested length is the window end (0x1F800) minus the start address. This may differ from the byte count that the command carries.

While a transfer runs, the gate counts bytes on the bus side.

- **Writes (host to card):** the first bytes, up to the real length, go on to the DMA port in order. Any bytes after that are accepted from the bus and dropped.
- **Reads (card to host):** the first bytes, up to the real length, are taken from the DMA stream. Any bytes after that are returned as 0x00, and nothing is pulled from the DMA side.

When the command's byte count runs out, a one-cycle done pulse reports how many real bytes moved. Two flags travel with it. One marks an underrun, where the command was shorter than the window asked for. The other marks an invalid access: an address past the window end, or a multi-byte command with a fixed address.

Top module: `fifo_window_gate`

## Requirements
- R1: A command is taken only when `cmd_func` equals 1 and `cmd_addr` is at or above the window base (0x090). Any other command leaves `cmd_ready` high, moves no data and gives no done pulse.
- R2: The requested length is 0x1F800 minus `cmd_addr`.
- R3: On a write (`cmd_write`=1), the first min(requested, transfer) bus bytes appear on `dma_wr_data` in order. Later bytes are accepted with `bus_wr_ready`=1 and never raise `dma_wr_valid`.
- R4: On a read (`cmd_write`=0), the first min(requested, transfer) bytes come from the DMA stream. Later bytes are 0x00 with `bus_rd_valid`=1 and `dma_rd_ready`=0.
- R5: A command with `cmd_single`=1 has a transfer length of 1, whatever `cmd_len` holds.
- R6: When the transfer length is below the requested length, only the transfer length moves and `done_underrun` is 1.
- R7: A `cmd_addr` at or above 0x1F800 gives a requested length of 0 and sets `done_invalid`. No byte is forwarded or pulled.
- R8: A multi-byte command with `cmd_opcode`=0 (fixed address) is invalid. It sets `done_invalid` and moves no real byte.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last bus beat, and `done_bytes` then holds the real byte count. A command with transfer length 0 pulses `done_o` in the cycle after acceptance, with a count of 0.
- R10: After reset, `cmd_ready` is 1 and `done_o` is 0. `cmd_ready` is 0 from the cycle after acceptance until the done cycle.
- R11: During the real part of a write, `bus_wr_ready` follows `dma_wr_ready`, so DMA back-pressure stalls the bus without losing or reordering bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Gate idle, command can be taken |
| cmd_func | input | 3 | Function number of the command |
| cmd_opcode | input | 1 | 1 = incrementing address |
| cmd_single | input | 1 | Single-byte command |
| cmd_write | input | 1 | 1 = host writes, 0 = host reads |
| cmd_addr | input | 17 | Start address |
| cmd_len | input | 17 | Transfer length in bytes (multi-byte) |
| bus_wr_valid | input | 1 | Bus write byte valid |
| bus_wr_ready | output | 1 | Bus write byte taken |
| bus_wr_data | input | 8 | Bus write byte |
| bus_rd_valid | output | 1 | Bus read byte valid |
| bus_rd_ready | input | 1 | Bus read byte taken |
| bus_rd_data | output | 8 | Bus read byte |
| dma_wr_valid | output | 1 | Byte offered to DMA |
| dma_wr_ready | input | 1 | DMA takes the byte |
| dma_wr_data | output | 8 | Byte to DMA |
| dma_rd_valid | input | 1 | DMA byte available |
| dma_rd_ready | output | 1 | Gate pulls DMA byte |
| dma_rd_data | input | 8 | Byte from DMA |
| done_o | output | 1 | Transfer finished pulse |
| done_bytes | output | 17 | Real bytes moved |
| done_underrun | output | 1 | Transfer shorter than requested |
| done_invalid | output | 1 | Bad address or opcode |

## Verification
A beat counter that drifts by one shifts the point where real data turns into padding. On the very next byte this shows as a zero where DMA data was expected, an extra DMA pull, or a byte forwarded that should have been dropped. A wrong latched length or direction shows within the transfer as the wrong handshake pair being active. It also shows one cycle after the last beat, as a missing or late `done_o` or a wrong `done_bytes`. Flag state captured at acceptance shows up only at the done pulse, so each scenario checks both flags there.

// File: rtl/wlg_pkg.sv
package wlg_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  // Bytes that are real for a transfer starting at addr.
  function automatic logic [31:0] win_req_len(input logic [31:0] addr,
                                              input logic [31:0] win_end);
    return (addr >= win_end) ? 32'd0 : (win_end - addr);
  endfunction

  function automatic logic [31:0] len_min(input logic [31:0] a,
                                          input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/wlg_cmd_decode.sv
module wlg_cmd_decode
  import wlg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned LEN_W    = 17,
  parameter int unsigned FUNC_W   = 3,
  parameter int unsigned FUNC_NUM = 1,
  parameter int unsigned WIN_BASE = 32'h0000_0090,
  parameter int unsigned WIN_END  = 32'h0001_F800
) (
  input  logic [FUNC_W-1:0] func,
  input  logic              opcode,
  input  logic              single,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              hit,
  output logic              addr_bad,
  output logic              opc_bad,
  output logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  xfer_len,
  output logic [LEN_W-1:0]  real_len,
  output logic              underrun
);
  localparam logic [31:0] BASE32 = 32'(WIN_BASE);
  localparam logic [31:0] END32  = 32'(WIN_END);

  logic [31:0] addr32;

  always_comb begin
    addr32   = 32'(addr);
    hit      = (func == FUNC_W'(FUNC_NUM)) && (addr32 >= BASE32);
    addr_bad = (addr32 >= END32);
    opc_bad  = !single && !opcode;
    req_len  = (addr_bad || opc_bad) ? '0 : LEN_W'(win_req_len(addr32, END32));
    xfer_len = single ? LEN_W'(1) : len;
    real_len = LEN_W'(len_min(32'(req_len), 32'(xfer_len)));
    underrun = (xfer_len < req_len);
  end

endmodule

// File: rtl/wlg_beat_counter.sv
module wlg_beat_counter #(
  parameter int unsigned LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_xfer,
  input  logic [LEN_W-1:0] load_real,
  input  logic             beat,
  output logic             busy,
  output logic             in_real,
  output logic             last_beat,
  output logic [LEN_W-1:0] moved_final
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] xfer_q;
  logic [LEN_W-1:0] real_q;
  logic [LEN_W-1:0] moved_q;
  logic             busy_q;

  assign busy        = busy_q;
  assign in_real     = busy_q && (cnt_q < real_q);
  assign last_beat   = busy_q && beat && (cnt_q == xfer_q - LEN_W'(1));
  assign moved_final = moved_q + (in_real ? LEN_W'(1) : LEN_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      xfer_q  <= '0;
      real_q  <= '0;
      moved_q <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      xfer_q  <= load_xfer;
      real_q  <= load_real;
      moved_q <= '0;
    end else if (busy_q && beat) begin
      cnt_q <= cnt_q + LEN_W'(1);
      if (in_real) moved_q <= moved_q + LEN_W'(1);
      if (last_beat) busy_q <= 1'b0;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < xfer_q));

  // R3
  real_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (moved_q <= real_q) && (real_q <= xfer_q));

  // R10
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

endmodule

// File: rtl/wlg_stream_steer.sv
module wlg_stream_steer
  import wlg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  dir_e              dir,
  input  logic              in_real,
  input  logic              bus_wr_valid,
  output logic              bus_wr_ready,
  input  logic [DATA_W-1:0] bus_wr_data,
  output logic              bus_rd_valid,
  input  logic              bus_rd_ready,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              dma_wr_valid,
  input  logic              dma_wr_ready,
  output logic [DATA_W-1:0] dma_wr_data,
  input  logic              dma_rd_valid,
  output logic              dma_rd_ready,
  input  logic [DATA_W-1:0] dma_rd_data,
  output logic              beat
);
  logic wr_act;
  logic rd_act;

  always_comb begin
    wr_act       = busy && (dir == DIR_WR);
    rd_act       = busy && (dir == DIR_RD);
    bus_wr_ready = wr_act && (in_real ? dma_wr_ready : 1'b1);
    dma_wr_valid = wr_act && in_real && bus_wr_valid;
    dma_wr_data  = bus_wr_data;
    bus_rd_valid = rd_act && (in_real ? dma_rd_valid : 1'b1);
    bus_rd_data  = (rd_act && in_real) ? dma_rd_data : '0;
    dma_rd_ready = rd_act && in_real && bus_rd_ready;
    beat         = (bus_wr_valid && bus_wr_ready) || (bus_rd_valid && bus_rd_ready);
  end

  // R4
  pad_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_real) |-> !dma_rd_ready);

  // R3
  pad_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_real) |-> !dma_wr_valid);

  // R11
  wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr_valid && dma_wr_ready) |-> (bus_wr_ready && beat));

endmodule

// File: rtl/fifo_window_gate.sv
module fifo_window_gate
  import wlg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned LEN_W    = 17,
  parameter int unsigned FUNC_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FUNC_NUM = 1,
  parameter int unsigned WIN_BASE = 32'h0000_0090,
  parameter int unsigned WIN_END  = 32'h0001_F800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic              cmd_opcode,
  input  logic              cmd_single,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              bus_wr_valid,
  output logic              bus_wr_ready,
  input  logic [DATA_W-1:0] bus_wr_data,
  output logic              bus_rd_valid,
  input  logic              bus_rd_ready,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              dma_wr_valid,
  input  logic              dma_wr_ready,
  output logic [DATA_W-1:0] dma_wr_data,
  input  logic              dma_rd_valid,
  output logic              dma_rd_ready,
  input  logic [DATA_W-1:0] dma_rd_data,
  output logic              done_o,
  output logic [LEN_W-1:0]  done_bytes,
  output logic              done_underrun,
  output logic              done_invalid
);
  // decode results
  logic             hit, addr_bad, opc_bad, underrun;
  logic [LEN_W-1:0] req_len, xfer_len, real_len;

  // internal events, named for the checks
  logic             cmd_fire, zero_go, load_go;
  logic             busy, in_real, last_beat, beat;
  logic [LEN_W-1:0] moved_final;

  dir_e dir_q;
  logic under_pend_q, inv_pend_q;
  logic done_q, done_under_q, done_inv_q;
  logic [LEN_W-1:0] done_bytes_q;

  wlg_cmd_decode #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FUNC_W(FUNC_W),
    .FUNC_NUM(FUNC_NUM), .WIN_BASE(WIN_BASE), .WIN_END(WIN_END)
  ) decode_i (
    .func(cmd_func), .opcode(cmd_opcode), .single(cmd_single),
    .addr(cmd_addr), .len(cmd_len),
    .hit(hit), .addr_bad(addr_bad), .opc_bad(opc_bad),
    .req_len(req_len), .xfer_len(xfer_len), .real_len(real_len),
    .underrun(underrun)
  );

  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready && hit;
  assign zero_go   = cmd_fire && (xfer_len == '0);
  assign load_go   = cmd_fire && (xfer_len != '0);

  wlg_beat_counter #(.LEN_W(LEN_W)) counter_i (
    .clk(clk), .rst_n(rst_n), .load(load_go),
    .load_xfer(xfer_len), .load_real(real_len), .beat(beat),
    .busy(busy), .in_real(in_real), .last_beat(last_beat),
    .moved_final(moved_final)
  );

  wlg_stream_steer #(.DATA_W(DATA_W)) steer_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir(dir_q), .in_real(in_real),
    .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready), .bus_wr_data(bus_wr_data),
    .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready), .bus_rd_data(bus_rd_data),
    .dma_wr_valid(dma_wr_valid), .dma_wr_ready(dma_wr_ready), .dma_wr_data(dma_wr_data),
    .dma_rd_valid(dma_rd_valid), .dma_rd_ready(dma_rd_ready), .dma_rd_data(dma_rd_data),
    .beat(beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q        <= DIR_RD;
      under_pend_q <= 1'b0;
      inv_pend_q   <= 1'b0;
      done_q       <= 1'b0;
      done_bytes_q <= '0;
      done_under_q <= 1'b0;
      done_inv_q   <= 1'b0;
    end else begin
      done_q <= last_beat || zero_go;
      if (cmd_fire) begin
        dir_q        <= cmd_write ? DIR_WR : DIR_RD;
        under_pend_q <= underrun;
        inv_pend_q   <= addr_bad || opc_bad;
      end
      if (zero_go) begin
        done_bytes_q <= '0;
        done_under_q <= underrun;
        done_inv_q   <= addr_bad || opc_bad;
      end else if (last_beat) begin
        done_bytes_q <= moved_final;
        done_under_q <= under_pend_q;
        done_inv_q   <= inv_pend_q;
      end
    end
  end

  assign done_o        = done_q;
  assign done_bytes    = done_bytes_q;
  assign done_underrun = done_under_q;
  assign done_invalid  = done_inv_q;

  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !zero_go) |=> !done_o);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done_o);

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> !cmd_ready);

  // R1
  foreign_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !hit) |=> (cmd_ready && !done_o));

  // R7
  invalid_no_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && addr_bad) |=> !in_real);

endmodule

// File: tb/fifo_window_gate_tb.sv
module fifo_window_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_opcode = 0, cmd_single = 0, cmd_write = 0;
  logic [2:0]  cmd_func = 0;
  logic [16:0] cmd_addr = 0, cmd_len = 0;
  logic        cmd_ready;
  logic        bus_wr_valid = 0, bus_rd_ready = 0, dma_wr_ready = 1, dma_rd_valid = 0;
  logic [7:0]  bus_wr_data = 0, dma_rd_data = 0;
  logic        bus_wr_ready, bus_rd_valid, dma_wr_valid, dma_rd_ready;
  logic [7:0]  bus_rd_data, dma_wr_data;
  logic        done_o, done_underrun, done_invalid;
  logic [16:0] done_bytes;

  fifo_window_gate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_func(cmd_func),
    .cmd_opcode(cmd_opcode), .cmd_single(cmd_single), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready), .bus_wr_data(bus_wr_data),
    .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready), .bus_rd_data(bus_rd_data),
    .dma_wr_valid(dma_wr_valid), .dma_wr_ready(dma_wr_ready), .dma_wr_data(dma_wr_data),
    .dma_rd_valid(dma_rd_valid), .dma_rd_ready(dma_rd_ready), .dma_rd_data(dma_rd_data),
    .done_o(done_o), .done_bytes(done_bytes),
    .done_underrun(done_underrun), .done_invalid(done_invalid)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] cap [0:15];
  int cap_n;
  int pulls;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench's own length model.
  function automatic int model_req(input int addr, input bit single, input bit opc);
    if (addr >= 'h1F800) return 0;
    if (!single && !opc) return 0;
    return 'h1F800 - addr;
  endfunction

  task automatic issue(input int func, input bit opc, input bit single, input bit wr,
                       input int addr, input int len, input bit expect_take, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_func = 3'(func); cmd_opcode = opc; cmd_single = single;
    cmd_write = wr; cmd_addr = 17'(addr); cmd_len = 17'(len);
    #1;
    chk(cmd_ready == 1'b1, req, cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 0;
    #1;
    chk(cmd_ready == !expect_take, req, cmd_ready, !expect_take);
  endtask

  task automatic write_bytes(input int n, input int real_exp, input int stall, input string req);
    int cyc = 0;
    cap_n = 0;
    for (int i = 0; i < n; i++) begin
      bit taken = 0;
      while (!taken) begin
        @(negedge clk);
        bus_wr_valid = 1; bus_wr_data = 8'(8'hA0 + i);
        dma_wr_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
        cyc++;
        #1;
        if (i < real_exp && !dma_wr_ready)
          chk(bus_wr_ready == 1'b0, "R11 stall", bus_wr_ready, 0);
        if (i >= real_exp && dma_wr_valid)
          chk(1'b0, {req, " pad forwarded"}, 1, 0);
        if (bus_wr_ready) begin
          taken = 1;
          if (dma_wr_valid && dma_wr_ready && cap_n < 16) begin
            cap[cap_n] = dma_wr_data; cap_n++;
          end
        end
      end
    end
    @(negedge clk);
    bus_wr_valid = 0; dma_wr_ready = 1;
    #1;
  endtask

  task automatic read_bytes(input int n);
    int src = 0;
    cap_n = 0; pulls = 0;
    for (int i = 0; i < n; i++) begin
      bit taken = 0;
      while (!taken) begin
        @(negedge clk);
        bus_rd_ready = 1; dma_rd_valid = 1; dma_rd_data = 8'(8'h30 + src);
        #1;
        if (bus_rd_valid) begin
          taken = 1;
          if (cap_n < 16) begin cap[cap_n] = bus_rd_data; cap_n++; end
          if (dma_rd_ready) begin src++; pulls++; end
        end
      end
    end
    @(negedge clk);
    bus_rd_ready = 0; dma_rd_valid = 0;
    #1;
  endtask

  task automatic check_done(input int bytes, input bit und, input bit inv, input string req);
    chk(done_o == 1'b1, {req, " done"}, done_o, 1);
    chk(done_bytes == 17'(bytes), {req, " bytes"}, done_bytes, bytes);
    chk(done_underrun == und, {req, " underrun"}, done_underrun, und);
    chk(done_invalid == inv, {req, " invalid"}, done_invalid, inv);
    @(negedge clk); #1;
    chk(done_o == 1'b0, "R9 pulse width", done_o, 0);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R10 reset ready", cmd_ready, 1);
    chk(done_o == 1'b0, "R10 reset done", done_o, 0);
    chk(dma_wr_valid == 1'b0 && bus_rd_valid == 1'b0, "R10 reset idle", 0, 0);
  endtask

  task automatic t_write_exact();
    int req = model_req('h1F7FC, 0, 1);   // R2: 4 bytes
    issue(1, 1, 0, 1, 'h1F7FC, 4, 1, "R10 busy");
    write_bytes(4, req, 0, "R2");
    chk(cap_n == req, "R2 count", cap_n, req);
    for (int i = 0; i < 4; i++) chk(cap[i] == 8'(8'hA0 + i), "R3 order", cap[i], 8'hA0 + i);
    check_done(4, 0, 0, "R9");
  endtask

  task automatic t_write_over();
    int req = model_req('h1F7FD, 0, 1);   // 3
    issue(1, 1, 0, 1, 'h1F7FD, 6, 1, "R1 take");
    write_bytes(6, req, 0, "R3");
    chk(cap_n == 3, "R3 dropped tail", cap_n, 3);
    chk(cap[2] == 8'hA2, "R3 last real", cap[2], 8'hA2);
    check_done(3, 0, 0, "R3");
  endtask

  task automatic t_write_stall();
    issue(1, 1, 0, 1, 'h1F7FA, 6, 1, "R11 take");
    write_bytes(6, 6, 2, "R11");
    chk(cap_n == 6, "R11 count", cap_n, 6);
    for (int i = 0; i < 6; i++) chk(cap[i] == 8'(8'hA0 + i), "R11 order", cap[i], 8'hA0 + i);
    check_done(6, 0, 0, "R11");
  endtask

  task automatic t_read_pad();
    issue(1, 1, 0, 0, 'h1F7FE, 5, 1, "R4 take");
    read_bytes(5);
    chk(pulls == 2, "R4 pulls", pulls, 2);
    chk(cap[0] == 8'h30 && cap[1] == 8'h31, "R4 real", cap[1], 8'h31);
    for (int i = 2; i < 5; i++) chk(cap[i] == 8'h00, "R4 zero pad", cap[i], 0);
    check_done(2, 0, 0, "R4");
  endtask

  task automatic t_read_under();
    issue(1, 1, 0, 0, 'h1F7F8, 3, 1, "R6 take");
    read_bytes(3);
    chk(pulls == 3, "R6 pulls", pulls, 3);
    chk(cap[2] == 8'h32, "R6 data", cap[2], 8'h32);
    check_done(3, 1, 0, "R6");
  endtask

  task automatic t_single();
    issue(1, 0, 1, 1, 'h1F7FB, 9, 1, "R5 take");
    write_bytes(1, 1, 0, "R5");
    chk(cap_n == 1 && cap[0] == 8'hA0, "R5 one byte", cap_n, 1);
    check_done(1, 1, 0, "R5");
    chk(bus_wr_ready == 1'b0 && cmd_ready == 1'b1, "R5 ended", bus_wr_ready, 0);
  endtask

  task automatic t_bad_addr();
    issue(1, 1, 0, 1, 'h1F800, 2, 1, "R7 take");
    write_bytes(2, 0, 0, "R7");
    chk(cap_n == 0, "R7 nothing forwarded", cap_n, 0);
    check_done(0, 0, 1, "R7");
  endtask

  task automatic t_bad_opc();
    issue(1, 0, 0, 0, 'h1F7FC, 3, 1, "R8 take");
    read_bytes(3);
    chk(pulls == 0, "R8 no pulls", pulls, 0);
    check_done(0, 0, 1, "R8");
  endtask

  task automatic t_foreign();
    issue(2, 1, 0, 1, 'h1F7FC, 4, 0, "R1 wrong func");
    @(negedge clk);
    bus_wr_valid = 1; bus_wr_data = 8'h55;
    #1;
    chk(bus_wr_ready == 1'b0 && dma_wr_valid == 1'b0, "R1 no data", bus_wr_ready, 0);
    chk(done_o == 1'b0, "R1 no done", done_o, 0);
    @(negedge clk);
    bus_wr_valid = 0;
    issue(1, 1, 0, 1, 'h10, 4, 0, "R1 below base");
    chk(done_o == 1'b0, "R1 below base done", done_o, 0);
  endtask

  task automatic t_zero();
    issue(1, 1, 0, 1, 'h1F7FC, 0, 0, "R9 zero take");
    check_done(0, 1, 0, "R9 zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_write_exact();
    t_write_over();
    t_write_stall();
    t_read_pad();
    t_read_under();
    t_single();
    t_bad_addr();
    t_bad_opc();
    t_foreign();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule